// File: doc/BRIEF.md
# Dual Timer Counter Peripheral

This peripheral holds one or two independent counters, each `DATA_W` bits wide (32 by default). Each counter sits behind a small register slot. Software writes a start value into the load register. It then writes the control register with the run bit set, and the counter restarts from that value. From there it counts either up toward all ones or down toward zero, one step per clock. On reaching the terminal value it raises a per-timer flag. If auto-reload is set, it then restarts from the load value on the next clock. Otherwise it stays at the terminal value.

All timers feed one level-sensitive interrupt output. Each timer contributes when both its flag and its interrupt-enable bit are set. Software clears a flag by writing one to the flag bit. The register port is synchronous and takes aligned 32-bit word accesses only. Read data comes back one clock after the request, with a valid strobe.

Top module: `twin_timer`

## Requirements
- R1: After reset, every control, load and counter register reads 0, and `irq_o` is 0.
- R2: Timer i occupies byte offsets 16*i+0 (control), +4 (load), +8 (counter) and +12 (unused). The control bits are: bit1 count down, bit4 auto-reload, bit6 interrupt enable, bit7 run, bit8 expiry flag. Bits 0, 2, 3, 5, 9 and 10 are stored and read back unchanged. Bits 31:11 read as 0.
- R3: The load register stores all 32 bits. The counter register and offset +12 ignore writes. Offset +12 reads 0.
- R4: A read returns, one clock after the request with `rvalid_o` high, the register state before the clock edge that samples the request. A control write with bit7 set puts the load value into the counter at that edge.
- R5: While bit7 is set, the counter steps once per clock. It goes up when bit1 is clear (terminal value all ones) and down when bit1 is set (terminal value 0).
- R6: The flag becomes 1 at the edge where the counter enters its terminal value. On the next edge, a timer with bit4 set reloads the load value. A timer with bit4 clear holds at the terminal value.
- R7: Writing a control word with bit8 set clears the flag, and a control write can never set it. If a clearing write lands on the edge where the counter enters its terminal value, the flag stays 1.
- R8: `irq_o` is 1 exactly when some present timer has both its flag and bit6 set. Each timer's registers are unaffected by accesses to the other timer.
- R9: With `NUM_TIMERS` = 1, all of slot 1 reads 0 and ignores writes, and `irq_o` never depends on it.
- R10: An access with `be_i` other than 4'b1111, or with `addr_i[1:0]` nonzero, changes no register. If it is a read, it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per clock |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| be_i | input | 4 | Byte enables; only 4'b1111 is a valid access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one clock after the request |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Shared level-sensitive interrupt |

## Verification
The hardest case to reach is a flag-clearing control write landing on the exact edge where a running counter enters its terminal value. The bench sets this up with a load value three steps below all ones and auto-reload enabled. It restarts the count with a clearing write, waits a counted number of idle clocks, and issues a second clearing write timed to be sampled on the expiry edge. It then checks that the interrupt is still asserted. Every counter read value is also predicted from the exact edge count since the last restart, which pins down the reload edge and the hold-at-terminal behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W  = 11;
  localparam int B_DOWN = 1;
  localparam int B_AUTO = 4;
  localparam int B_IEN  = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_access_dec.sv
module tmr_access_dec
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int SLOT_W     = 1,
  parameter int AW         = 5
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [3:0]            be_i,
  output logic [NUM_TIMERS-1:0] wr_ctl_o,
  output logic [NUM_TIMERS-1:0] wr_load_o,
  output logic                  rd_en_o,
  output logic                  rd_ok_o,
  output logic [SLOT_W-1:0]     rd_slot_o,
  output reg_sel_e              rd_sel_o
);
  logic              full_word;
  logic              present;
  logic [SLOT_W-1:0] slot;
  reg_sel_e          sel;

  assign full_word = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
  assign slot      = addr_i[AW-1:4];
  assign sel       = reg_sel_e'(addr_i[3:2]);
  assign present   = 32'(slot) < NUM_TIMERS;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
    logic hit;
    assign hit          = req_i && we_i && full_word && (slot == SLOT_W'(i));
    assign wr_ctl_o[i]  = hit && (sel == SEL_CTL);
    assign wr_load_o[i] = hit && (sel == SEL_LOAD);
  end

  assign rd_en_o   = req_i && !we_i;
  assign rd_ok_o   = full_word && present && (sel != SEL_NONE);
  assign rd_slot_o = slot;
  assign rd_sel_o  = sel;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctl_i,
  input  logic             wr_load_i,
  input  logic [W-1:0]     wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [W-1:0]     load_o,
  output logic [W-1:0]     cnt_o,
  output logic             irq_o
);
  localparam logic [CTL_W-1:0] FLAG_MASK = CTL_W'(1) << B_FLAG;

  logic [CTL_W-1:0] cfg_q;
  logic             flag_q;
  logic [W-1:0]     load_q, cnt_q;
  logic [W-1:0]     term, step, nxt;
  logic             down, run, autor, at_term, adv, expire, restart, clr;

  assign down    = cfg_q[B_DOWN];
  assign run     = cfg_q[B_RUN];
  assign autor   = cfg_q[B_AUTO];
  assign term    = down ? '0 : '1;
  assign at_term = (cnt_q == term);
  assign step    = down ? cnt_q - 1'b1 : cnt_q + 1'b1;
  // parked at terminal without reload: no motion
  assign adv     = run && !(at_term && !autor);
  assign nxt     = at_term ? load_q : step;
  // expiry is independent of a concurrent register write
  assign expire  = adv && (nxt == term);
  assign restart = wr_ctl_i && wdata_i[B_RUN];
  assign clr     = wr_ctl_i && wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctl_i)  cfg_q  <= wdata_i[CTL_W-1:0] & ~FLAG_MASK;
      if (wr_load_i) load_q <= wdata_i;
      if (restart)   cnt_q  <= load_q;
      else if (adv)  cnt_q  <= nxt;
      flag_q <= (flag_q && !clr) || expire;
    end
  end

  assign ctl_o  = cfg_q | (flag_q ? FLAG_MASK : '0);
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = flag_q && cfg_q[B_IEN];

  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(run)); // R7
  AST_RESTART_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> cnt_q == $past(load_q)); // R4
  AST_RELOAD_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && at_term && autor && !wr_ctl_i |=> cnt_q == $past(load_q)); // R6
  AST_HOLD_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && at_term && !autor && !wr_ctl_i |=> $stable(cnt_q)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !wr_ctl_i |=> $stable(cnt_q)); // R5
  AST_CLEAR_LOSES_TO_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && run && !at_term && (step == term) |=> flag_q); // R7
endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] req_i,
  output logic         irq_o
);
  if (N == 1) begin : g_single
    assign irq_o = req_i[0];
  end else begin : g_multi
    assign irq_o = |req_i;
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int MAX_TIMERS = 2,
  parameter int DATA_W     = 32,
  localparam int SLOT_W    = (MAX_TIMERS > 1) ? $clog2(MAX_TIMERS) : 1,
  localparam int AW        = SLOT_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic [NUM_TIMERS-1:0] wr_ctl, wr_load, irq_req;
  logic                  rd_en, rd_ok;
  logic [SLOT_W-1:0]     rd_slot;
  reg_sel_e              rd_sel;
  logic [CTL_W-1:0]      ctl_a  [NUM_TIMERS];
  logic [DATA_W-1:0]     load_a [NUM_TIMERS];
  logic [DATA_W-1:0]     cnt_a  [NUM_TIMERS];
  logic [DATA_W-1:0]     rd_val, rdata_q;
  logic                  rvalid_q;

  tmr_access_dec #(.NUM_TIMERS(NUM_TIMERS), .SLOT_W(SLOT_W), .AW(AW)) u_dec (
    .req_i, .we_i, .addr_i, .be_i,
    .wr_ctl_o(wr_ctl), .wr_load_o(wr_load),
    .rd_en_o(rd_en), .rd_ok_o(rd_ok), .rd_slot_o(rd_slot), .rd_sel_o(rd_sel)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    tmr_unit #(.W(DATA_W)) u_unit (
      .clk_i, .rst_ni,
      .wr_ctl_i(wr_ctl[i]), .wr_load_i(wr_load[i]), .wdata_i,
      .ctl_o(ctl_a[i]), .load_o(load_a[i]), .cnt_o(cnt_a[i]), .irq_o(irq_req[i])
    );
  end

  tmr_irq_merge #(.N(NUM_TIMERS)) u_irq (.req_i(irq_req), .irq_o);

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rd_ok && rd_slot == SLOT_W'(i)) begin
        case (rd_sel)
          SEL_CTL:  rd_val = DATA_W'(ctl_a[i]);
          SEL_LOAD: rd_val = load_a[i];
          SEL_CNT:  rd_val = cnt_a[i];
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? rd_val : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R4
  AST_PARTIAL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && $past(be_i != 4'hF) |-> rdata_o == '0); // R10
  AST_ABSENT_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && $past(32'(addr_i[AW-1:4]) >= NUM_TIMERS) |-> rdata_o == '0); // R9
endmodule

// File: tb/twin_timer_tb.sv
module twin_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  logic        req1 = 1'b0, we1 = 1'b0;
  logic [4:0]  addr1 = '0;
  logic [31:0] wdata1 = '0;
  logic [31:0] rdata1;
  logic        rvalid1, irq1;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  twin_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  twin_timer #(.NUM_TIMERS(1)) u_dut_one (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .we_i(we1), .addr_i(addr1),
    .be_i(4'hF), .wdata_i(wdata1), .rdata_o(rdata1), .rvalid_o(rvalid1), .irq_o(irq1)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk(rdata, 32'hX, "R4 unexpected rvalid");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag,
                    input logic [3:0] b = 4'hF);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0; be = 4'hF;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input logic [4:0] a, input logic [31:0] d);
    req1 = 1'b1; we1 = 1'b1; addr1 = a; wdata1 = d;
    @(negedge clk);
    req1 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd1(input logic [4:0] a, input logic [31:0] e, input string tag);
    req1 = 1'b1; we1 = 1'b0; addr1 = a;
    @(negedge clk);
    req1 = 1'b0;
    chk(rdata1, e, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq after reset");
    rd(5'h00, 32'h0, "R1 ctl0");
    rd(5'h04, 32'h0, "R1 load0");
    rd(5'h08, 32'h0, "R1 cnt0");
    rd(5'h10, 32'h0, "R1 ctl1");

    // R2 stored width, flag not settable
    wr(5'h10, 32'hFFFF_FF7F);
    chk({31'b0, irq}, 32'h0, "R7 flag not set by write");
    rd(5'h10, 32'h0000_067F, "R2 ctl low bits only");
    wr(5'h10, 32'h0);

    // R3 load, counter read-only, unused slot
    wr(5'h04, 32'h1234_5678);
    rd(5'h04, 32'h1234_5678, "R3 load readback");
    wr(5'h08, 32'hDEAD_BEEF);
    rd(5'h08, 32'h0, "R3 counter ignores write");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R3 unused word");

    // R5/R6 down count, no reload
    wr(5'h04, 32'd10);
    wr(5'h00, 32'h0000_00C2);
    rd(5'h08, 32'd10, "R4 restart from load");
    rd(5'h08, 32'd9, "R5 down step");
    tick(7);
    chk({31'b0, irq}, 32'h0, "R6 no flag before terminal");
    tick(1);
    chk({31'b0, irq}, 32'h1, "R6 flag on entering zero");
    rd(5'h08, 32'd0, "R6 at terminal");
    rd(5'h08, 32'd0, "R6 hold without reload");
    rd(5'h00, 32'h0000_01C2, "R2 flag bit8");
    wr(5'h00, 32'h0000_0142);
    chk({31'b0, irq}, 32'h0, "R7 write-one clear");
    rd(5'h00, 32'h0000_0042, "R7 flag cleared");

    // R5/R6 up count with reload
    wr(5'h04, 32'hFFFF_FFFC);
    wr(5'h00, 32'h0000_00D0);
    rd(5'h08, 32'hFFFF_FFFC, "R4 restart up");
    rd(5'h08, 32'hFFFF_FFFD, "R5 up step");
    rd(5'h08, 32'hFFFF_FFFE, "R5 up step 2");
    chk({31'b0, irq}, 32'h1, "R6 flag on all ones");
    rd(5'h08, 32'hFFFF_FFFF, "R6 terminal up");
    rd(5'h08, 32'hFFFF_FFFC, "R6 auto reload");
    wr(5'h00, 32'h0000_01D0);
    chk({31'b0, irq}, 32'h0, "R7 clear while running");
    tick(2);
    wr(5'h00, 32'h0000_01D0); // sampled on expiry edge
    chk({31'b0, irq}, 32'h1, "R7 clear loses to expiry");
    rd(5'h00, 32'h0000_01D0, "R7 flag kept");
    rd(5'h08, 32'hFFFF_FFFD, "R4 restarted on clear write");
    tick(2);
    wr(5'h00, 32'h0000_0100);
    chk({31'b0, irq}, 32'h0, "R8 irq low after clear");

    // R8 second timer, shared irq, independence
    wr(5'h14, 32'd2);
    wr(5'h10, 32'h0000_0082);
    tick(3);
    chk({31'b0, irq}, 32'h0, "R8 flag without enable");
    rd(5'h10, 32'h0000_0182, "R8 timer1 flag");
    wr(5'h10, 32'h0000_0042);
    chk({31'b0, irq}, 32'h1, "R8 enable drives irq");
    rd(5'h00, 32'h0, "R8 timer0 untouched");
    rd(5'h04, 32'hFFFF_FFFC, "R8 load0 untouched");
    wr(5'h10, 32'h0000_0100);
    chk({31'b0, irq}, 32'h0, "R8 irq released");

    // R10 partial and misaligned accesses
    wr(5'h14, 32'h55, 4'b0011);
    rd(5'h14, 32'd2, "R10 partial write ignored");
    wr(5'h15, 32'h66);
    rd(5'h14, 32'd2, "R10 misaligned write ignored");
    rd(5'h14, 32'h0, "R10 partial read zero", 4'b0001);

    // R9 single-timer variant
    wr1(5'h14, 32'h77);
    rd1(5'h14, 32'h0, "R9 absent load");
    wr1(5'h04, 32'h77);
    rd1(5'h04, 32'h77, "R9 present load");
    wr1(5'h10, 32'h0000_00C2);
    tick(4);
    rd1(5'h10, 32'h0, "R9 absent ctl");
    chk({31'b0, irq1}, 32'h0, "R9 no irq from absent slot");

    tick(3);
    chk(32'(exp_q.size()), 32'h0, "R4 all reads returned");
    summary();
  end
endmodule